// File: doc/BRIEF.md
# MSI Coherent Child Cache Controller

This block is the coherence engine on the processor side of a small direct-mapped cache with one data word per line. Every line holds a tag, a word of data, an MSI state and a pending-wait record. The processor presents loads and stores at the head of a request queue. The controller answers hits at once. On a miss it asks the parent for a higher state and holds the processor request at the head of the queue until the grant arrives, so the cache is blocking.

The parent talks to the controller over a parent-to-child queue. That queue carries two kinds of message. Upgrade grants raise a line's state. Downgrade demands lower it, and the controller drops such a demand when the line is already low enough. The controller sends its own upgrade requests and downgrade replies on a child-to-parent channel. Each outgoing message is tagged with source and destination IDs.

When a new address maps to a line that still holds another address, the controller first gives the old address up to I. This is an unsolicited downgrade reply, and it carries the data when the line was in M. Only after that does the controller ask for the new address. The controller handles at most one message per cycle, and parent traffic is always served before the processor.

Top module: `msi_child_cache`

## Requirements
- R1: After reset every line is in I with no wait pending, and all output valids are low. The first access to any address therefore misses.
- R2: A load whose tag matches and whose line state is S or M is dequeued in that cycle. The stored word appears on the processor response one cycle later, and no parent message is sent.
- R3: A store hits only when its tag matches and the line is in M. It writes the word and returns an acknowledgement one cycle later.
- R4: A miss with no wait pending records a wait and sends one upgrade request. The request carries the full address and a target of S for a load or M for a store. The processor request stays queued, and no further parent message goes out while the wait is pending.
- R5: An upgrade response sets the line to the granted state and clears the wait. It writes the carried data only if the line was in I before the response.
- R6: A downgrade request to target y, for a held address whose state is above y, is answered one cycle later by a downgrade response with state y. The response carries the data if and only if the line was in M, and the line then moves to y.
- R7: A downgrade request is removed with no reply and no state change when its target is at or above the line's state, or when its address is not held.
- R8: A processor access whose line holds a different address in S or M first sends a voluntary downgrade response to I for the old address, with data if and only if it was in M. The upgrade request for the new address follows on the next cycle.
- R9: A valid parent message is always dequeued in preference to the processor request, and at most one message is dequeued per cycle.
- R10: State codes are I=0, S=1, M=2. Every outgoing message carries source CHILD_ID and destination PARENT_ID, and the address index is its low IDX_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preq_valid | input | 1 | Processor request present at queue head |
| preq_store | input | 1 | 1 = store, 0 = load |
| preq_addr | input | ADDR_W | Processor word address |
| preq_wdata | input | DATA_W | Store data |
| preq_ready | output | 1 | Processor request dequeued this cycle |
| presp_valid | output | 1 | Processor response pulse |
| presp_ack | output | 1 | Response is a store acknowledgement |
| presp_data | output | DATA_W | Load data (zero for acknowledgements) |
| p2c_valid | input | 1 | Parent message present at queue head |
| p2c_is_resp | input | 1 | 1 = upgrade response, 0 = downgrade request |
| p2c_addr | input | ADDR_W | Parent message address |
| p2c_state | input | 2 | Granted or demanded state |
| p2c_data | input | DATA_W | Data carried by an upgrade response |
| p2c_ready | output | 1 | Parent message dequeued this cycle |
| c2p_valid | output | 1 | Child-to-parent message pulse |
| c2p_is_resp | output | 1 | 1 = downgrade response, 0 = upgrade request |
| c2p_src | output | ID_W | Source ID (CHILD_ID) |
| c2p_dst | output | ID_W | Destination ID (PARENT_ID) |
| c2p_addr | output | ADDR_W | Message address |
| c2p_state | output | 2 | Requested or new state |
| c2p_has_data | output | 1 | Data field is meaningful |
| c2p_data | output | DATA_W | Dirty data on a downgrade from M |

## Verification
The assertions assume the parent behaves like a correct directory. It sends an upgrade response only for the address and state that were requested. It never demands a downgrade to M, and it accepts every child message at once. The bench plays that parent. It answers each upgrade request with exactly the target state for the address that was sent. The unsolicited grant used for R5 goes only to a line already in that state, and downgrade targets stay within I and S. Demands for addresses the cache does not hold still reach the controller, so that the drop path is exercised.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} msi_t;

  typedef struct packed {
    logic vld;
    msi_t tgt;
  } wait_t;

  function automatic msi_t need_of(input logic is_store);
    return is_store ? ST_M : ST_S;
  endfunction

  function automatic logic covers(input msi_t have, input msi_t need);
    return have >= need;
  endfunction

  function automatic logic dirty(input msi_t s);
    return s == ST_M;
  endfunction
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output msi_t              a_state,
  output logic [TAG_W-1:0]  a_tag,
  output wait_t             a_wait,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output msi_t              b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic              we_state,
  input  msi_t              w_state,
  input  logic              we_tag,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic              we_wait,
  input  wait_t             w_wait,
  input  logic              we_data,
  input  logic [DATA_W-1:0] w_data
);
  localparam int LINES = 1 << IDX_W;

  msi_t              st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  wait_t             wt_q  [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = (w_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
        wt_q[g]  <= '0;
        dat_q[g] <= '0;
      end else begin
        if (sel && we_state) st_q[g]  <= w_state;
        if (sel && we_tag)   tag_q[g] <= w_tag;
        if (sel && we_wait)  wt_q[g]  <= w_wait;
        if (sel && we_data)  dat_q[g] <= w_data;
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_wait  = wt_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = dat_q[b_idx];

  AST_NO_DOUBLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_wait && w_wait.vld) |-> !wt_q[w_idx].vld); // R4

  AST_FILL_ONLY_FROM_I: assert property (@(posedge clk) disable iff (!rst_n)
    (we_data && we_wait && !w_wait.vld) |-> (st_q[w_idx] == ST_I)); // R5
endmodule

// File: rtl/msi_step.sv
module msi_step
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              preq_valid,
  input  logic              preq_store,
  input  logic [ADDR_W-1:0] preq_addr,
  input  logic [DATA_W-1:0] preq_wdata,
  input  logic              p2c_valid,
  input  logic              p2c_is_resp,
  input  logic [ADDR_W-1:0] p2c_addr,
  input  msi_t              p2c_state,
  input  logic [DATA_W-1:0] p2c_data,
  input  msi_t              a_state,
  input  logic [TAG_W-1:0]  a_tag,
  input  wait_t             a_wait,
  input  logic [DATA_W-1:0] a_data,
  input  msi_t              b_state,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [DATA_W-1:0] b_data,
  output logic              preq_deq,
  output logic              p2c_deq,
  output logic [IDX_W-1:0]  w_idx,
  output logic              we_state,
  output msi_t              w_state,
  output logic              we_tag,
  output logic [TAG_W-1:0]  w_tag,
  output logic              we_wait,
  output wait_t             w_wait,
  output logic              we_data,
  output logic [DATA_W-1:0] w_data,
  output logic              send_c2p,
  output logic              send_is_resp,
  output logic [ADDR_W-1:0] send_addr,
  output msi_t              send_state,
  output logic              send_has_data,
  output logic [DATA_W-1:0] send_data,
  output logic              send_presp,
  output logic              send_ack,
  output logic [DATA_W-1:0] send_pdata,
  output logic              ev_store_hit,
  output logic              ev_evict
);
  logic [IDX_W-1:0] p_idx, q_idx;
  logic [TAG_W-1:0] p_tag, q_tag;
  msi_t             need;
  logic             p_match, q_match;

  assign p_idx   = preq_addr[IDX_W-1:0];
  assign p_tag   = preq_addr[ADDR_W-1:IDX_W];
  assign q_idx   = p2c_addr[IDX_W-1:0];
  assign q_tag   = p2c_addr[ADDR_W-1:IDX_W];
  assign need    = need_of(preq_store);
  assign p_match = (a_tag == p_tag) && (a_state != ST_I);
  assign q_match = (b_tag == q_tag) && (b_state != ST_I);

  always_comb begin
    preq_deq      = 1'b0;
    p2c_deq       = 1'b0;
    w_idx         = p_idx;
    we_state      = 1'b0;
    w_state       = ST_I;
    we_tag        = 1'b0;
    w_tag         = p_tag;
    we_wait       = 1'b0;
    w_wait        = '0;
    we_data       = 1'b0;
    w_data        = preq_wdata;
    send_c2p      = 1'b0;
    send_is_resp  = 1'b0;
    send_addr     = preq_addr;
    send_state    = ST_I;
    send_has_data = 1'b0;
    send_data     = '0;
    send_presp    = 1'b0;
    send_ack      = 1'b0;
    send_pdata    = '0;
    ev_store_hit  = 1'b0;
    ev_evict      = 1'b0;
    if (p2c_valid) begin
      p2c_deq = 1'b1;
      w_idx   = q_idx;
      if (p2c_is_resp) begin
        we_state = 1'b1;
        w_state  = p2c_state;
        we_wait  = 1'b1;
        w_wait   = '0;
        if (b_state == ST_I) begin
          we_data = 1'b1;
          w_data  = p2c_data;
        end
      end else if (q_match && (b_state > p2c_state)) begin
        we_state      = 1'b1;
        w_state       = p2c_state;
        send_c2p      = 1'b1;
        send_is_resp  = 1'b1;
        send_addr     = p2c_addr;
        send_state    = p2c_state;
        send_has_data = dirty(b_state);
        send_data     = dirty(b_state) ? b_data : '0;
      end
    end else if (preq_valid) begin
      if (p_match && covers(a_state, need)) begin
        preq_deq   = 1'b1;
        send_presp = 1'b1;
        if (preq_store) begin
          we_data      = 1'b1;
          send_ack     = 1'b1;
          ev_store_hit = 1'b1;
        end else begin
          send_pdata = a_data;
        end
      end else if (a_wait.vld) begin
        preq_deq = 1'b0;
      end else if (a_state != ST_I && !p_match) begin
        ev_evict      = 1'b1;
        we_state      = 1'b1;
        w_state       = ST_I;
        send_c2p      = 1'b1;
        send_is_resp  = 1'b1;
        send_addr     = {a_tag, p_idx};
        send_state    = ST_I;
        send_has_data = dirty(a_state);
        send_data     = dirty(a_state) ? a_data : '0;
      end else begin
        we_wait    = 1'b1;
        w_wait     = '{vld: 1'b1, tgt: need};
        we_tag     = 1'b1;
        send_c2p   = 1'b1;
        send_state = need;
      end
    end
  end
endmodule

// File: rtl/msi_child_cache.sv
module msi_child_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 2,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 4,
  parameter int CHILD_ID  = 1,
  parameter int PARENT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preq_valid,
  input  logic              preq_store,
  input  logic [ADDR_W-1:0] preq_addr,
  input  logic [DATA_W-1:0] preq_wdata,
  output logic              preq_ready,
  output logic              presp_valid,
  output logic              presp_ack,
  output logic [DATA_W-1:0] presp_data,
  input  logic              p2c_valid,
  input  logic              p2c_is_resp,
  input  logic [ADDR_W-1:0] p2c_addr,
  input  logic [1:0]        p2c_state,
  input  logic [DATA_W-1:0] p2c_data,
  output logic              p2c_ready,
  output logic              c2p_valid,
  output logic              c2p_is_resp,
  output logic [ID_W-1:0]   c2p_src,
  output logic [ID_W-1:0]   c2p_dst,
  output logic [ADDR_W-1:0] c2p_addr,
  output logic [1:0]        c2p_state,
  output logic              c2p_has_data,
  output logic [DATA_W-1:0] c2p_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  msi_t              a_state, b_state, w_state, send_state;
  logic [TAG_W-1:0]  a_tag, b_tag, w_tag;
  wait_t             a_wait, w_wait;
  logic [DATA_W-1:0] a_data, b_data, w_data, send_data, send_pdata;
  logic [IDX_W-1:0]  w_idx;
  logic              we_state, we_tag, we_wait, we_data;
  logic              preq_deq, p2c_deq;
  logic              send_c2p, send_is_resp, send_has_data;
  logic              send_presp, send_ack;
  logic [ADDR_W-1:0] send_addr;
  logic              ev_store_hit, ev_evict;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .a_idx(preq_addr[IDX_W-1:0]), .a_state(a_state), .a_tag(a_tag),
    .a_wait(a_wait), .a_data(a_data),
    .b_idx(p2c_addr[IDX_W-1:0]), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .w_idx(w_idx), .we_state(we_state), .w_state(w_state),
    .we_tag(we_tag), .w_tag(w_tag), .we_wait(we_wait), .w_wait(w_wait),
    .we_data(we_data), .w_data(w_data)
  );

  msi_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_step (
    .preq_valid(preq_valid), .preq_store(preq_store), .preq_addr(preq_addr),
    .preq_wdata(preq_wdata),
    .p2c_valid(p2c_valid), .p2c_is_resp(p2c_is_resp), .p2c_addr(p2c_addr),
    .p2c_state(msi_t'(p2c_state)), .p2c_data(p2c_data),
    .a_state(a_state), .a_tag(a_tag), .a_wait(a_wait), .a_data(a_data),
    .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .preq_deq(preq_deq), .p2c_deq(p2c_deq),
    .w_idx(w_idx), .we_state(we_state), .w_state(w_state),
    .we_tag(we_tag), .w_tag(w_tag), .we_wait(we_wait), .w_wait(w_wait),
    .we_data(we_data), .w_data(w_data),
    .send_c2p(send_c2p), .send_is_resp(send_is_resp), .send_addr(send_addr),
    .send_state(send_state), .send_has_data(send_has_data), .send_data(send_data),
    .send_presp(send_presp), .send_ack(send_ack), .send_pdata(send_pdata),
    .ev_store_hit(ev_store_hit), .ev_evict(ev_evict)
  );

  assign preq_ready = preq_deq;
  assign p2c_ready  = p2c_deq;
  assign c2p_src    = ID_W'(CHILD_ID);
  assign c2p_dst    = ID_W'(PARENT_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presp_valid  <= 1'b0;
      presp_ack    <= 1'b0;
      presp_data   <= '0;
      c2p_valid    <= 1'b0;
      c2p_is_resp  <= 1'b0;
      c2p_addr     <= '0;
      c2p_state    <= '0;
      c2p_has_data <= 1'b0;
      c2p_data     <= '0;
    end else begin
      presp_valid  <= send_presp;
      presp_ack    <= send_ack;
      presp_data   <= send_pdata;
      c2p_valid    <= send_c2p;
      c2p_is_resp  <= send_is_resp;
      c2p_addr     <= send_addr;
      c2p_state    <= send_state;
      c2p_has_data <= send_has_data;
      c2p_data     <= send_data;
    end
  end

  AST_PARENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    preq_ready |-> !p2c_valid); // R9

  AST_ONE_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({preq_ready, p2c_ready}) <= 1); // R9

  AST_STORE_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store_hit |-> (a_state == ST_M)); // R3

  AST_DN_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
    (c2p_valid && c2p_is_resp) |-> (c2p_state != 2'd2)); // R6

  AST_UP_ABOVE_I: assert property (@(posedge clk) disable iff (!rst_n)
    (c2p_valid && !c2p_is_resp) |-> (c2p_state != 2'd0 && !c2p_has_data)); // R4

  AST_EVICT_THEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_evict && preq_valid) |=> (c2p_valid && c2p_is_resp && c2p_state == 2'd0)); // R8

  AST_ONE_OUT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(c2p_valid && presp_valid)); // R9
endmodule

// File: tb/msi_child_cache_bench.sv
`timescale 1ns/1ps
module msi_child_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        preq_valid = 1'b0, preq_store = 1'b0;
  logic [7:0]  preq_addr = '0;
  logic [15:0] preq_wdata = '0;
  logic        preq_ready, presp_valid, presp_ack;
  logic [15:0] presp_data;
  logic        p2c_valid = 1'b0, p2c_is_resp = 1'b0;
  logic [7:0]  p2c_addr = '0;
  logic [1:0]  p2c_state = '0;
  logic [15:0] p2c_data = '0;
  logic        p2c_ready, c2p_valid, c2p_is_resp, c2p_has_data;
  logic [3:0]  c2p_src, c2p_dst;
  logic [7:0]  c2p_addr;
  logic [1:0]  c2p_state;
  logic [15:0] c2p_data;

  int n_chk = 0, n_bad = 0;
  int m_state [4];
  int m_tag   [4];
  int m_data  [4];

  always #2.5 clk = ~clk;

  msi_child_cache u_msi_child_cache (
    .clk(clk), .rst_n(rst_n),
    .preq_valid(preq_valid), .preq_store(preq_store), .preq_addr(preq_addr),
    .preq_wdata(preq_wdata), .preq_ready(preq_ready),
    .presp_valid(presp_valid), .presp_ack(presp_ack), .presp_data(presp_data),
    .p2c_valid(p2c_valid), .p2c_is_resp(p2c_is_resp), .p2c_addr(p2c_addr),
    .p2c_state(p2c_state), .p2c_data(p2c_data), .p2c_ready(p2c_ready),
    .c2p_valid(c2p_valid), .c2p_is_resp(c2p_is_resp), .c2p_src(c2p_src),
    .c2p_dst(c2p_dst), .c2p_addr(c2p_addr), .c2p_state(c2p_state),
    .c2p_has_data(c2p_has_data), .c2p_data(c2p_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // processor access with the bench acting as parent
  task automatic proc_op(input bit st, input int a, input int wd, input int fill);
    int idx = a % 4;
    int tg  = a / 4;
    int need = st ? 2 : 1;
    preq_valid = 1'b1; preq_store = st; preq_addr = 8'(a); preq_wdata = 16'(wd);
    if (m_state[idx] != 0 && m_tag[idx] != tg) begin
      tick();
      chk(c2p_valid && c2p_is_resp, "R8 evict resp", {c2p_valid, c2p_is_resp}, 3);
      chk(c2p_addr == 8'(m_tag[idx] * 4 + idx), "R8 evict addr", c2p_addr, m_tag[idx] * 4 + idx);
      chk(c2p_state == 2'd0, "R8 evict state", c2p_state, 0);
      chk(c2p_has_data == (m_state[idx] == 2), "R8 evict data flag", c2p_has_data, m_state[idx] == 2);
      if (m_state[idx] == 2) chk(c2p_data == 16'(m_data[idx]), "R8 evict data", c2p_data, m_data[idx]);
      m_state[idx] = 0;
    end
    if (!(m_state[idx] != 0 && m_tag[idx] == tg && m_state[idx] >= need)) begin
      tick();
      chk(c2p_valid && !c2p_is_resp, "R4 upgrade req", {c2p_valid, c2p_is_resp}, 2);
      chk(c2p_addr == 8'(a), "R4 req addr", c2p_addr, a);
      chk(c2p_state == 2'(need), "R4 req target", c2p_state, need);
      chk(c2p_src == 4'd1 && c2p_dst == 4'd0, "R10 ids", {c2p_src, c2p_dst}, 16);
      tick();
      chk(!c2p_valid && !presp_valid, "R4 blocked while waiting", {c2p_valid, presp_valid}, 0);
      p2c_valid = 1'b1; p2c_is_resp = 1'b1; p2c_addr = 8'(a);
      p2c_state = 2'(need); p2c_data = 16'(fill);
      #1;
      chk(p2c_ready && !preq_ready, "R9 parent first", {p2c_ready, preq_ready}, 2);
      tick();
      p2c_valid = 1'b0;
      if (m_state[idx] == 0) m_data[idx] = fill;
      m_state[idx] = need; m_tag[idx] = tg;
    end
    #1;
    chk(preq_ready, "R2/R3 hit dequeue", preq_ready, 1);
    tick();
    preq_valid = 1'b0;
    chk(presp_valid && !c2p_valid, "R2/R3 hit response only", {presp_valid, c2p_valid}, 2);
    if (st) begin
      chk(presp_ack, "R3 store ack", presp_ack, 1);
      m_data[idx] = wd;
    end else begin
      chk(!presp_ack && presp_data == 16'(m_data[idx]), "R2 load data", presp_data, m_data[idx]);
    end
  endtask

  task automatic dn_req(input int a, input int y);
    int idx = a % 4;
    int tg  = a / 4;
    p2c_valid = 1'b1; p2c_is_resp = 1'b0; p2c_addr = 8'(a); p2c_state = 2'(y); p2c_data = 16'hdead;
    #1;
    chk(p2c_ready, "R9 downgrade dequeue", p2c_ready, 1);
    tick();
    p2c_valid = 1'b0;
    if (m_state[idx] != 0 && m_tag[idx] == tg && m_state[idx] > y) begin
      chk(c2p_valid && c2p_is_resp, "R6 dn resp", {c2p_valid, c2p_is_resp}, 3);
      chk(c2p_state == 2'(y) && c2p_addr == 8'(a), "R6 dn state/addr", c2p_state, y);
      chk(c2p_has_data == (m_state[idx] == 2), "R6 data flag", c2p_has_data, m_state[idx] == 2);
      if (m_state[idx] == 2) chk(c2p_data == 16'(m_data[idx]), "R6 dirty data", c2p_data, m_data[idx]);
      m_state[idx] = y;
    end else begin
      chk(!c2p_valid, "R7 stale request dropped", c2p_valid, 0);
    end
  endtask

  task automatic unsol_resp(input int a, input int y, input int d);
    int idx = a % 4;
    p2c_valid = 1'b1; p2c_is_resp = 1'b1; p2c_addr = 8'(a); p2c_state = 2'(y); p2c_data = 16'(d);
    tick();
    p2c_valid = 1'b0;
    chk(!c2p_valid && !presp_valid, "R5 resp silent", c2p_valid, 0);
    if (m_state[idx] == 0) m_data[idx] = d;
    m_state[idx] = y;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_state[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!presp_valid && !c2p_valid && !preq_ready && !p2c_ready, "R1 reset quiet",
        {presp_valid, c2p_valid, preq_ready, p2c_ready}, 0);
    for (int i = 0; i < 4; i++) begin
      int a = (i + 1) * 4 + i;
      int b = (i + 9) * 4 + i;
      proc_op(0, a, 0, 100 + i);        // R1 miss from I, fill to S
      proc_op(0, a, 0, 0);              // R2 hit in S
      proc_op(1, a, 200 + i, 999);      // S->M upgrade then store
      proc_op(1, a, 210 + i, 0);        // R3 store hit in M
      dn_req(a, 1);                     // R6 M->S with data
      proc_op(0, a, 0, 0);
      unsol_resp(a, 1, 777);            // R5 data ignored when not I
      proc_op(0, a, 0, 0);
      dn_req(a, 1);                     // R7 already S
      dn_req(b, 0);                     // R7 address not held
      dn_req(a, 0);                     // R6 S->I, no data
      dn_req(a, 0);                     // R7 already I
      proc_op(0, a, 0, 300 + i);        // R5 refill from I
      proc_op(1, a, 400 + i, 0);
      proc_op(0, b, 0, 500 + i);        // R8 evict dirty
      proc_op(1, a, 600 + i, 700 + i);  // R8 evict clean, store miss from I
      proc_op(0, a, 0, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule